// File: doc/BRIEF.md
# Bus-Silence Safety Supervisor with Advisory Owner Lock

This block keeps the 8-bit command register of a bus-attached I/O node and assembles its 8-bit status word. It decides whether the node runs in normal mode or has fallen back to safety mode. It drives the node's interrupt line. The bus controller reports three kinds of frame event to it, each as a one-cycle pulse: a well-formed frame seen on the bus, a frame identified as addressing this node, and a write to port A. A slow tick input paces two silence windows. With no access at all since reset, the longer window of four base periods applies. Once the node has been accessed, the base window applies, and it expires only if well-formed bus traffic was seen while the node itself was left alone.

The command register has three parts. A surveillance-inhibit bit stops any entry into safety mode and turns the interrupt into a one-cycle pulse per addressed frame. A busy bit and a 3-bit owner number form an advisory lock between bus masters that share the peripheral. The lock is only reported and never blocks anything. The low three bits belong to a separate line-selection block. A write whose low field is the keep code changes only the upper five bits.

Top module: `safety_supervisor`

## Requirements
- R1: After reset the command output is 0x00, status bit 3 is 0 and the interrupt output is 0.
- R2: With no node access and no port A write since reset, safety mode is entered on exactly the 4*LONG_TICKS-th tick; status bit 3 and the interrupt read 1 from the next cycle on.
- R3: Once an access has occurred, safety mode is entered on the LONG_TICKS-th tick after the latest node access or port A write, provided a well-formed frame was seen since that access; every node access or port A write restarts the window.
- R4: If no well-formed frame was seen since the latest access, the base window holds at its last step and does not expire; after a well-formed frame arrives, the next tick enters safety mode.
- R5: In safety mode the interrupt and status bit 3 are 1; a port A write clears both on the next cycle whatever the busy bit holds, and the silence window then restarts.
- R6: With command bit 3 = 1, safety mode is never entered; the interrupt is then 1 for exactly the one cycle that follows each node-access pulse.
- R7: A command write is accepted in every mode, taking effect the next cycle; status bits 7..4 always mirror command bits 7..4 (bit 7 busy, bits 6..4 owner number).
- R8: A command write whose bits 2..0 equal 3'b011 updates bits 7..3 only and leaves bits 2..0 unchanged.
- R9: Status bits 2..0 show the line-status input from the line-selection block unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle slow time-base strobe |
| frame_ok | input | 1 | Pulse: well-formed frame seen on the bus |
| node_access | input | 1 | Pulse: identified frame addressed this node |
| port_a_write | input | 1 | Pulse: port A was written |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command write data |
| line_stat | input | 3 | Line-selection status from the line block |
| cmd_q_o | output | 8 | Current command register |
| status_o | output | 8 | Status word |
| int_o | output | 1 | Interrupt / safety indication |

## Verification
The hardest state to reach is the base-window expiry of R4. It needs the node to have been accessed already, then a full window with no access, then a well-formed frame that arrives only after the counter has parked at its last step. The bench first leaves the node silent long enough to reach safety mode. It then exits with a port A write, which arms the base window. It then issues more ticks than the window holds with no frame and confirms that nothing happens. Only then does it pulse a frame and give the one tick that must tip the node into safety mode.

// File: rtl/ssv_pkg.sv
package ssv_pkg;
    localparam int CMD_W   = 8;
    localparam int OWN_W   = 3;
    localparam int SEL_W   = 3;
    localparam logic [SEL_W-1:0] SEL_KEEP = 3'b011;

    typedef struct packed {
        logic             busy;
        logic [OWN_W-1:0] owner;
        logic             inhibit;
        logic [SEL_W-1:0] line_sel;
    } cmd_t;

    typedef struct packed {
        logic safe;
        logic pulse;
    } mode_t;
endpackage

// File: rtl/ssv_cmd_reg.sv
module ssv_cmd_reg
    import ssv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CMD_W-1:0] wdata,
    output cmd_t             cmd_o
);
    cmd_t cmd_d, cmd_q;
    cmd_t wr;

    always_comb begin
        wr    = cmd_t'(wdata);
        cmd_d = cmd_q;
        if (we) begin
            cmd_d = wr;
            if (wr.line_sel == SEL_KEEP)
                cmd_d.line_sel = cmd_q.line_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign cmd_o = cmd_q;
endmodule

// File: rtl/ssv_silence_timer.sv
module ssv_silence_timer #(
    parameter int LONG_TICKS = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic frame_ok,
    input  logic enable,
    output logic expire
);
    localparam int SLOW_TICKS = 4 * LONG_TICKS;
    localparam int CNT_W      = $clog2(SLOW_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(LONG_TICKS - 1);
    localparam logic [CNT_W-1:0] LAST_SLOW  = CNT_W'(SLOW_TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             seen;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [CNT_W-1:0] last;
    logic             at_last;
    logic             qualify;

    always_comb begin
        last    = tmr_q.armed ? LAST_SHORT : LAST_SLOW;
        at_last = (tmr_q.cnt == last);
        qualify = !tmr_q.armed || tmr_q.seen;
        expire  = enable && !restart && tick && at_last && qualify;

        tmr_d = tmr_q;
        if (restart) begin
            tmr_d.armed = 1'b1;
            tmr_d.seen  = 1'b0;
        end else if (frame_ok) begin
            tmr_d.seen  = 1'b1;
        end

        if (restart || !enable)
            tmr_d.cnt = '0;
        else if (tick && !at_last)
            tmr_d.cnt = tmr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/ssv_mode_ctrl.sv
module ssv_mode_ctrl
    import ssv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic port_a_write,
    input  logic node_access,
    input  logic inhibit,
    output logic safe,
    output logic irq
);
    mode_t mode_d, mode_q;

    always_comb begin
        mode_d       = mode_q;
        mode_d.pulse = inhibit && node_access;
        if (port_a_write)
            mode_d.safe = 1'b0;
        else if (expire)
            mode_d.safe = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    assign safe = mode_q.safe;
    assign irq  = mode_q.safe | mode_q.pulse;
endmodule

// File: rtl/safety_supervisor.sv
module safety_supervisor
    import ssv_pkg::*;
#(
    parameter int LONG_TICKS = 500000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             frame_ok,
    input  logic             node_access,
    input  logic             port_a_write,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic [SEL_W-1:0] line_stat,
    output logic [CMD_W-1:0] cmd_q_o,
    output logic [CMD_W-1:0] status_o,
    output logic             int_o
);
    cmd_t cmd;
    logic safe;
    logic expire;
    logic restart;
    logic watch_en;

    assign restart  = node_access | port_a_write;
    assign watch_en = !cmd.inhibit && !safe;

    ssv_cmd_reg u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cmd_we),
        .wdata (cmd_wdata),
        .cmd_o (cmd)
    );

    ssv_silence_timer #(.LONG_TICKS(LONG_TICKS)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .restart  (restart),
        .frame_ok (frame_ok),
        .enable   (watch_en),
        .expire   (expire)
    );

    ssv_mode_ctrl u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .expire       (expire),
        .port_a_write (port_a_write),
        .node_access  (node_access),
        .inhibit      (cmd.inhibit),
        .safe         (safe),
        .irq          (int_o)
    );

    assign cmd_q_o  = cmd;
    assign status_o = {cmd.busy, cmd.owner, safe, line_stat};
endmodule

// File: rtl/ssv_checker.sv
module ssv_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       node_access,
    input logic       port_a_write,
    input logic       cmd_we,
    input logic [7:0] cmd_wdata,
    input logic [7:0] cmd_q_o,
    input logic [7:0] status_o,
    input logic       int_o
);
    AST_EXIT_ON_PORT_A: assert property (@(posedge clk) disable iff (!rst_n)
        port_a_write |=> !status_o[3]); // R5

    AST_INHIBIT_HOLDS_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q_o[3] && !status_o[3]) |=> !status_o[3]); // R6

    AST_CMD_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata[2:0] != 3'b011) |=> cmd_q_o == $past(cmd_wdata)); // R7

    AST_CMD_KEEP_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata[2:0] == 3'b011)
        |=> (cmd_q_o[2:0] == $past(cmd_q_o[2:0]) && cmd_q_o[7:3] == $past(cmd_wdata[7:3]))); // R8

    AST_ENTRY_NEEDS_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[3]) |-> $past(!node_access && !port_a_write && !cmd_q_o[3])); // R2

    AST_SAFE_RAISES_INT: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[3] |-> int_o); // R5
endmodule

bind safety_supervisor ssv_checker i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .node_access  (node_access),
    .port_a_write (port_a_write),
    .cmd_we       (cmd_we),
    .cmd_wdata    (cmd_wdata),
    .cmd_q_o      (cmd_q_o),
    .status_o     (status_o),
    .int_o        (int_o)
);

// File: tb/test_safety_supervisor.sv
module test_safety_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int T = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, frame_ok = 1'b0, node_access = 1'b0, port_a_write = 1'b0;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_wdata = '0;
    logic [2:0] line_stat = 3'b000;
    logic [7:0] cmd_q_o, status_o;
    logic       int_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    safety_supervisor #(.LONG_TICKS(T)) i_safety_supervisor (
        .clk(clk), .rst_n(rst_n), .tick(tick), .frame_ok(frame_ok),
        .node_access(node_access), .port_a_write(port_a_write),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .line_stat(line_stat),
        .cmd_q_o(cmd_q_o), .status_o(status_o), .int_o(int_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; step(); tick = 1'b0; step();
        end
    endtask

    task automatic pulse_frame();  frame_ok = 1'b1;     step(); frame_ok = 1'b0;     endtask
    task automatic pulse_access(); node_access = 1'b1;  step(); node_access = 1'b0;  endtask
    task automatic pulse_porta();  port_a_write = 1'b1; step(); port_a_write = 1'b0; endtask
    task automatic wr_cmd(input logic [7:0] v);
        cmd_we = 1'b1; cmd_wdata = v; step(); cmd_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 cmd", cmd_q_o, 8'h00);
        check("R1 safe", {7'd0, status_o[3]}, 8'h00);
        check("R1 int", {7'd0, int_o}, 8'h00);
    endtask

    task automatic t_cmd_writes();
        wr_cmd(8'hD5);
        check("R7 write", cmd_q_o, 8'hD5);
        check("R7 mirror", {status_o[7:4], 4'h0}, 8'hD0);
        wr_cmd(8'h23);
        check("R8 keep sel", cmd_q_o, 8'h25);
        wr_cmd(8'h00);
        check("R7 clear", cmd_q_o, 8'h00);
    endtask

    task automatic t_line_stat();
        line_stat = 3'b101; step();
        check("R9 line", {5'd0, status_o[2:0]}, 8'h05);
        line_stat = 3'b000; step();
    endtask

    task automatic t_slow_window();
        do_ticks(4*T - 1);
        check("R2 before", {6'd0, status_o[3], int_o}, 8'h00);
        do_ticks(1);
        check("R2 entered", {6'd0, status_o[3], int_o}, 8'h03);
    endtask

    task automatic t_exit_locked();
        wr_cmd(8'hE2);
        check("R7 write in safety", cmd_q_o, 8'hE2);
        check("R7 busy owner", {status_o[7:4], 4'h0}, 8'hE0);
        check("R5 still safe", {7'd0, int_o}, 8'h01);
        pulse_porta();
        check("R5 exit", {6'd0, status_o[3], int_o}, 8'h00);
    endtask

    task automatic t_no_frame();
        do_ticks(3*T);
        check("R4 held", {6'd0, status_o[3], int_o}, 8'h00);
        pulse_frame();
        check("R4 frame only", {7'd0, status_o[3]}, 8'h00);
        do_ticks(1);
        check("R4 entered", {6'd0, status_o[3], int_o}, 8'h03);
        pulse_porta();
        check("R5 exit again", {7'd0, int_o}, 8'h00);
    endtask

    task automatic t_base_window();
        pulse_access();
        pulse_frame();
        do_ticks(T - 1);
        check("R3 before", {7'd0, status_o[3]}, 8'h00);
        pulse_access();
        pulse_frame();
        do_ticks(T - 1);
        check("R3 restarted", {7'd0, status_o[3]}, 8'h00);
        do_ticks(1);
        check("R3 entered", {6'd0, status_o[3], int_o}, 8'h03);
        pulse_porta();
        check("R5 exit third", {7'd0, status_o[3]}, 8'h00);
    endtask

    task automatic t_inhibit();
        wr_cmd(8'h0B);
        check("R8 inhibit keep", cmd_q_o, 8'h0A);
        pulse_frame();
        do_ticks(5*T);
        check("R6 never safe", {6'd0, status_o[3], int_o}, 8'h00);
        node_access = 1'b1; step(); node_access = 1'b0;
        check("R6 pulse high", {7'd0, int_o}, 8'h01);
        step();
        check("R6 pulse low", {7'd0, int_o}, 8'h00);
    endtask

    initial begin
        fork
            begin
                repeat (3) step();
                rst_n = 1'b1;
                step();
                t_reset();
                t_cmd_writes();
                t_line_stat();
                t_slow_window();
                t_exit_locked();
                t_no_frame();
                t_base_window();
                t_inhibit();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule